// File: doc/BRIEF.md
# Redundant Radix SAR Conversion Controller

This block controls the digital side of a successive-approximation converter. The capacitor array uses a radix below two, so the bit weights add up to more than the full output range. A one-cycle sample strobe starts a conversion. The controller then runs fourteen trials, from the most significant step down to the least significant one. Each trial asks the comparator for a decision with a start pulse, and waits for the comparator to report that the decision is ready.

For every step the controller drives a two-bit code that tells the DAC which way that capacitor switches. It also builds the output word from the kept bits. The output is the sum of a programmable integer weight for each bit decided as 1, plus a signed offset, clamped to twelve bits. The controller derives a per-trial time budget from the sampling period, so that a slow or metastable comparator cannot hold up the conversion: when the budget runs out, the trial is closed with a 0 decision.

Top module: `sar_redundant_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `cmp_start_o` are low, `data_o` is 0 and every DAC code pair is 2'b00.
- R2: A `sample_i` high at a clock edge while idle starts a conversion. In the following cycle `busy_o` and `cmp_start_o` are high and all DAC code pairs read 2'b00.
- R3: Trials run from step NRAW-1 down to step 0. Each trial's decision is taken at the first edge at which `cmp_ready_i` is high, and the next trial's `cmp_start_o` pulse appears in the cycle right after that edge.
- R4: DAC code pair k sits at bits [2k+1:2k] of `dac_code_o`. Its value is 2'b00 while step k is undecided, 2'b10 once step k is decided as 1, and 2'b01 once it is decided as 0. The code is updated at the deciding edge.
- R5: At the start of a conversion, `budget_o` is loaded with floor((period_i - 2) / NRAW), with a minimum of 1, and keeps that value for the rest of the conversion.
- R6: If `cmp_ready_i` stays low for `budget_o` cycles after a trial's start pulse, the step is decided as 0. The next trial's start pulse is then seen exactly `budget_o` cycles after the previous one.
- R7: `data_o` equals the offset plus the sum of the weights of the steps decided as 1. Weight k is field [k*WW +: WW] of `weights_i`.
- R8: The reconstructed value is clamped: a negative sum gives 0, and a sum above 4095 gives 4095.
- R9: `done_o` is high for exactly one cycle, one cycle after the edge of the last decision. At that point `busy_o` is low, and `data_o` holds its value until the next `done_o`.
- R10: A `sample_i` pulse that arrives during a conversion is ignored. The conversion continues and keeps the decisions it has already taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Start-of-conversion strobe |
| period_i | input | PW | Sampling period in clock cycles |
| weights_i | input | NRAW*WW | Programmable step weights, with step k in field k |
| offset_i | input | ACCW+1 | Signed offset added to the weighted sum |
| cmp_start_o | output | 1 | One-cycle request for a comparator decision |
| cmp_ready_i | input | 1 | Comparator decision is ready |
| cmp_decision_i | input | 1 | Comparator result, where 1 keeps the step |
| dac_code_o | output | 2*NRAW | Per-step DAC switch codes |
| budget_o | output | PW | Per-trial cycle budget |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Result-valid pulse |
| data_o | output | OUTW | Reconstructed, clamped output word |

## Verification
A new trial's start pulse appears one cycle after the deciding edge. A timed-out trial ends `budget_o` cycles after its start pulse. The DAC code of a step changes at the edge that decides it, and `done_o` with the new `data_o` arrives one cycle after the last deciding edge. The bench acts as the comparator: it drives its inputs on the falling edge and reads the outputs on the next falling edge, so each result is read in the cycle it is due. The bench also reads the cycle just before `done_o` and the cycle just after it, to confirm that the done pulse is neither early nor stretched.

// File: rtl/sar_redundant_ctrl.sv
module sar_redundant_ctrl #(
  parameter int NRAW = 14,
  parameter int OUTW = 12,
  parameter int WW   = 13,
  parameter int PW   = 12,
  parameter int OVH  = 2,
  localparam int KW   = $clog2(NRAW),
  localparam int ACCW = WW + $clog2(NRAW)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sample_i,
  input  logic [PW-1:0]          period_i,
  input  logic [NRAW*WW-1:0]     weights_i,
  input  logic signed [ACCW:0]   offset_i,
  output logic                   cmp_start_o,
  input  logic                   cmp_ready_i,
  input  logic                   cmp_decision_i,
  output logic [2*NRAW-1:0]      dac_code_o,
  output logic [PW-1:0]          budget_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [OUTW-1:0]        data_o
);

  typedef enum logic [1:0] {S_IDLE, S_TRIAL, S_FINISH} state_t;
  localparam logic [ACCW:0] TOP = (ACCW+1)'((1 << OUTW) - 1);

  state_t          st;
  logic [KW-1:0]   k;
  logic [PW-1:0]   tmr, bud_q;
  logic [ACCW-1:0] acc;

  wire [PW-1:0] span    = (period_i > PW'(OVH)) ? period_i - PW'(OVH) : '0;
  wire [PW-1:0] quot    = span / PW'(NRAW);
  wire [PW-1:0] bud_new = (quot == '0) ? PW'(1) : quot;

  wire [WW-1:0] wk    = weights_i[k*WW +: WW];
  wire          take  = (st == S_TRIAL) && cmp_ready_i;
  wire          lapse = (st == S_TRIAL) && !cmp_ready_i && (tmr == bud_q - 1'b1);
  wire          bit_d = take && cmp_decision_i;
  wire          step  = take || lapse;

  wire signed [ACCW+1:0] total = $signed({2'b00, acc}) + $signed({offset_i[ACCW], offset_i});
  wire [OUTW-1:0] sat = total[ACCW+1] ? '0 :
                        (total[ACCW:0] > TOP) ? TOP[OUTW-1:0] : total[OUTW-1:0];

  assign budget_o = bud_q;
  assign busy_o   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      k           <= '0;
      tmr         <= '0;
      bud_q       <= PW'(1);
      acc         <= '0;
      dac_code_o  <= '0;
      cmp_start_o <= 1'b0;
      done_o      <= 1'b0;
      data_o      <= '0;
    end else begin
      cmp_start_o <= 1'b0;
      done_o      <= 1'b0;
      case (st)
        S_IDLE: if (sample_i) begin
          st          <= S_TRIAL;
          k           <= KW'(NRAW-1);
          tmr         <= '0;
          bud_q       <= bud_new;
          acc         <= '0;
          dac_code_o  <= '0;
          cmp_start_o <= 1'b1;
        end
        S_TRIAL: if (step) begin
          dac_code_o[2*k +: 2] <= bit_d ? 2'b10 : 2'b01;
          if (bit_d) acc <= acc + ACCW'(wk);
          tmr <= '0;
          if (k == '0) st <= S_FINISH;
          else begin
            k           <= k - 1'b1;
            cmp_start_o <= 1'b1;
          end
        end else begin
          tmr <= tmr + 1'b1;
        end
        default: begin
          data_o <= sat;
          done_o <= 1'b1;
          st     <= S_IDLE;
        end
      endcase
    end
  end

  function automatic logic codes_resolved(input logic [2*NRAW-1:0] c);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NRAW; i++)
      if (c[2*i +: 2] == 2'b00 || c[2*i +: 2] == 2'b11) ok = 1'b0;
    return ok;
  endfunction

  a_r6_within_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRIAL) |-> (tmr < bud_q));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_start_o |-> busy_o);
  a_r4_codes_final: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> codes_resolved(dac_code_o));
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && sample_i) |=> !(cmp_start_o && k == KW'(NRAW-1)));
  a_r5_budget_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (budget_o != '0));

endmodule

// File: tb/tb_sar_redundant_ctrl.sv
`timescale 1ns/1ps
module tb_sar_redundant_ctrl;
  localparam int NRAW = 14, OUTW = 12, WW = 13, PW = 12;
  localparam int ACCW = WW + $clog2(NRAW);

  logic clk = 0, rst_n = 0, sample = 0, ready = 0, dec = 0;
  logic [PW-1:0] period = 100;
  logic [NRAW*WW-1:0] wvec;
  logic signed [ACCW:0] offset = -18'sd168;
  logic cmp_start, busy, done;
  logic [2*NRAW-1:0] dac;
  logic [PW-1:0] budget;
  logic [OUTW-1:0] data;
  int checks = 0, errors = 0;
  int W [NRAW] = '{1, 2, 3, 6, 10, 18, 32, 58, 104, 188, 338, 608, 1094, 1970};

  always #10 clk = ~clk;

  always_comb begin
    wvec = '0;
    for (int i = 0; i < NRAW; i++) wvec[i*WW +: WW] = WW'(W[i]);
  end

  sar_redundant_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .period_i(period),
    .weights_i(wvec), .offset_i(offset), .cmp_start_o(cmp_start),
    .cmp_ready_i(ready), .cmp_decision_i(dec), .dac_code_o(dac),
    .budget_o(budget), .busy_o(busy), .done_o(done), .data_o(data));

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_budget(input int p);
    int q;
    q = (p > 2) ? (p - 2) / NRAW : 0;
    return (q == 0) ? 1 : q;
  endfunction

  function automatic int exp_out(input logic [NRAW-1:0] b);
    int s;
    s = int'(offset);
    for (int i = 0; i < NRAW; i++) if (b[i]) s += W[i];
    if (s < 0) s = 0;
    if (s > 4095) s = 4095;
    return s;
  endfunction

  task automatic run_conv(input logic [NRAW-1:0] bits, input logic [NRAW-1:0] tom,
                          input int dly, input int inj, input string tag);
    int n;
    logic [NRAW-1:0] kept;
    int ebud, ev;
    kept = bits & ~tom;
    ebud = exp_budget(int'(period));
    ev   = exp_out(kept);
    sample = 1; @(negedge clk); sample = 0;
    chk(busy && cmp_start && dac == '0, {"R2 start ", tag}, longint'({busy, cmp_start}), 3);
    chk(int'(budget) == ebud, {"R5 budget ", tag}, budget, ebud);
    for (int k = NRAW-1; k >= 0; k--) begin
      n = 0;
      while (!cmp_start && n < 100) begin @(negedge clk); n++; end
      chk(cmp_start == 1'b1, {"R3 trial start ", tag}, cmp_start, 1);
      if (tom[k]) begin
        n = 0;
        do begin @(negedge clk); n++; end while (!cmp_start && n < 100);
        chk(n == ebud, {"R6 timeout length ", tag}, n, ebud);
        chk(dac[2*k +: 2] == 2'b01, {"R6 forced zero ", tag}, dac[2*k +: 2], 1);
      end else begin
        for (int j = 0; j < dly; j++) begin
          sample = (j == 0 && inj == k);
          @(negedge clk);
        end
        sample = 0;
        ready = 1; dec = bits[k];
        @(negedge clk);
        ready = 0;
        chk(dac[2*k +: 2] == (bits[k] ? 2'b10 : 2'b01), {"R4 code ", tag},
            dac[2*k +: 2], bits[k] ? 2 : 1);
        if (k > 0) chk(cmp_start == 1'b1, {"R3 next start ", tag}, cmp_start, 1);
        if (inj == k)
          chk(busy && dac[2*(NRAW-1) +: 2] == (bits[NRAW-1] ? 2'b10 : 2'b01),
              {"R10 ignored strobe ", tag}, dac[2*(NRAW-1) +: 2], bits[NRAW-1] ? 2 : 1);
      end
    end
    chk(!done, {"R9 not early ", tag}, done, 0);
    @(negedge clk);
    chk(done && !busy, {"R9 done ", tag}, done, 1);
    chk(int'(data) == ev, {"R7 R8 data ", tag}, data, ev);
    @(negedge clk);
    chk(!done && int'(data) == ev, {"R9 pulse/hold ", tag}, done, 0);
  endtask

  task automatic t_reset;
    rst_n = 0; repeat (2) @(negedge clk);
    chk(!busy && !done && !cmp_start, "R1 flags", {busy, done, cmp_start}, 0);
    chk(data == '0, "R1 data", data, 0);
    chk(dac == '0, "R1 dac", dac, 0);
    rst_n = 1; @(negedge clk);
    chk(!busy, "R1 idle after release", busy, 0);
  endtask

  task automatic t_budget;
    period = 10;  run_conv(14'h2AAA, '0, 0, -1, "period10");
    period = 44;  run_conv(14'h1555, '0, 0, -1, "period44");
    period = 100; run_conv(14'h0F0F, '0, 0, -1, "period100");
  endtask

  task automatic t_patterns;
    run_conv(14'h3C3C, '0, 3, -1, "dly3");
    run_conv(14'h2001, '0, 6, -1, "dly_edge");
    run_conv(14'h1234, '0, 1, -1, "dly1");
  endtask

  task automatic t_timeout;
    run_conv(14'h3FFE, 14'h0408, 2, -1, "timeout");
  endtask

  task automatic t_saturate;
    run_conv(14'h3FFF, '0, 0, -1, "sat_high");
    run_conv(14'h0000, '0, 0, -1, "sat_low");
    offset = 18'sd37;
    run_conv(14'h0000, '0, 0, -1, "pos_offset");
    offset = -18'sd168;
  endtask

  task automatic t_ignore;
    run_conv(14'h2B6D, '0, 2, 7, "ignore");
  endtask

  initial begin
    t_reset;
    t_budget;
    t_patterns;
    t_timeout;
    t_saturate;
    t_ignore;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule